// File: doc/BRIEF.md
# Sequential Signed Fractional Divider

This block divides one 32-bit two's-complement fraction by another. The dividend is read as a fraction whose low half is all zeros, so the quotient is also a proper fraction. The block first reduces both operands to magnitudes and records the sign of the result. It refuses any pair whose quotient could not be a proper fraction. Otherwise it runs one restoring shift/compare/subtract step per clock, rounds the result and gives it the correct sign.

A client raises `start` for one cycle while the unit is idle. The unit then holds `busy` until it pulses `done`. In that cycle `quotient` holds the new result and `overflow` tells whether the division was refused. A refused division leaves `quotient` at its previous value.

Top module: `frac_divider`

## Requirements
- R1: After reset, `busy`, `done`, `overflow` and `quotient` are all 0.
- R2: A `start` seen while the unit is idle captures `dividend` and `divisor` and raises `busy` from the next cycle. A `start` seen while `busy` is high is ignored and has no effect on the result that follows.
- R3: When |dividend| >= |divisor|, compared as unsigned magnitudes, the unit refuses the division. This includes every case with a zero divisor. `done` and `overflow` go high after the second rising edge counted from the accepting edge, and `quotient` keeps its previous value.
- R4: The result is negative exactly when the sign bits (bit 31) of the two operands differ. A negative operand is turned into its magnitude by two's-complement negation, so 0x80000000 has magnitude 2^31.
- R5: An accepted division runs exactly 31 iterations. Each iteration shifts a 31-bit partial quotient left, doubles the partial remainder, and subtracts the divisor magnitude, appending a 1, when the doubled remainder is not below that magnitude.
- R6: The 31-bit partial quotient is rounded by adding 1 and then clearing bit 0, so a successful quotient always has bit 0 equal to 0.
- R7: When the result is negative, the rounded value is negated in two's complement before it is presented. The 32-bit result wraps, so a rounded magnitude of 2^31 appears as 0x80000000 with either sign.
- R8: A successful division raises `done`, with `overflow` = 0, 33 rising edges after the accepting edge.
- R9: `done` is a single-cycle pulse, and `busy` is low whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; honoured only while idle |
| dividend | input | 32 | Two's-complement fraction to be divided |
| divisor | input | 32 | Two's-complement fraction to divide by |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Signed, rounded quotient of the last successful division |
| overflow | output | 1 | Last division was refused (valid with `done`, held after) |

## Verification
The bench concentrates on the limits of the magnitude comparison: equal magnitudes of opposite sign, a zero divisor with a zero dividend, and the most negative value on either side. A design that compared signed values, or that used `>` in place of `>=`, would return a quotient in place of overflow in these cases. It also checks the case whose rounded magnitude reaches 2^31. An extra quotient bit or a missing rounding step gives the wrong word there. Opposite-sign pairs would expose a result that was never negated, and a restart with different operands in the middle of a division would expose a design that accepted `start` while busy.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  typedef enum logic [1:0] {
    FDV_IDLE = 2'd0,
    FDV_PREP = 2'd1,
    FDV_RUN  = 2'd2,
    FDV_FIN  = 2'd3
  } fdv_state_e;
endpackage

// File: rtl/fdiv_prep.sv
// Operand conditioning: magnitudes, result sign, and the proper-fraction test.
module fdiv_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvr,
  output logic [W-1:0] dvd_mag,
  output logic [W-1:0] dvr_mag,
  output logic         res_neg,
  output logic         too_big
);
  function automatic logic [W-1:0] magnitude(input logic [W-1:0] v);
    return v[W-1] ? (~v + 1'b1) : v;
  endfunction

  always_comb begin
    dvd_mag = magnitude(dvd);
    dvr_mag = magnitude(dvr);
    res_neg = dvd[W-1] ^ dvr[W-1];
    too_big = (dvd_mag >= dvr_mag);
  end
endmodule

// File: rtl/fdiv_step.sv
// One restoring iteration: shift, compare, conditional subtract.
module fdiv_step #(
  parameter int W = 32
) (
  input  logic [W:0]   rem_in,
  input  logic [W-1:0] quo_in,
  input  logic [W-1:0] dvr_mag,
  output logic [W:0]   rem_out,
  output logic [W-1:0] quo_out,
  output logic         bit_set
);
  function automatic logic [W:0] doubled(input logic [W:0] r);
    return {r[W-1:0], 1'b0};
  endfunction

  logic [W:0] dbl;

  always_comb begin
    dbl     = doubled(rem_in);
    bit_set = (dbl >= {1'b0, dvr_mag});
    rem_out = bit_set ? (dbl - {1'b0, dvr_mag}) : dbl;
    quo_out = {quo_in[W-2:0], bit_set};
  end
endmodule

// File: rtl/fdiv_finish.sv
// Rounding (add one, clear the low bit) followed by sign restoration.
module fdiv_finish #(
  parameter int W = 32
) (
  input  logic [W-1:0] quo_raw,
  input  logic         res_neg,
  output logic [W-1:0] result
);
  function automatic logic [W-1:0] round_even(input logic [W-1:0] q);
    logic [W-1:0] s;
    s = q + 1'b1;
    return {s[W-1:1], 1'b0};
  endfunction

  function automatic logic [W-1:0] apply_sign(input logic [W-1:0] m, input logic n);
    return n ? (~m + 1'b1) : m;
  endfunction

  always_comb result = apply_sign(round_even(quo_raw), res_neg);
endmodule

// File: rtl/frac_divider.sv
module frac_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic         overflow
);
  import frac_div_pkg::*;

  localparam int ITERS = W - 1;
  localparam int CNT_W = $clog2(ITERS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ITERS - 1);

  fdv_state_e      state_q;
  logic [W-1:0]    op_dvd_q, op_dvr_q;
  logic [W-1:0]    dvr_mag_q;
  logic            neg_q;
  logic [W:0]      rem_q;
  logic [W-1:0]    quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]    result_q;
  logic            ovf_q;
  logic            done_q;

  // Internal events, named for the checker
  logic accept, ovf_detect, step_fire, last_step, finish_fire;

  logic [W-1:0] p_dvd_mag, p_dvr_mag;
  logic         p_neg, p_too_big;
  logic [W:0]   s_rem;
  logic [W-1:0] s_quo;
  logic         s_bit;
  logic [W-1:0] f_result;

  fdiv_prep #(.W(W)) u_prep (
    .dvd     (op_dvd_q),
    .dvr     (op_dvr_q),
    .dvd_mag (p_dvd_mag),
    .dvr_mag (p_dvr_mag),
    .res_neg (p_neg),
    .too_big (p_too_big)
  );

  fdiv_step #(.W(W)) u_step (
    .rem_in  (rem_q),
    .quo_in  (quo_q),
    .dvr_mag (dvr_mag_q),
    .rem_out (s_rem),
    .quo_out (s_quo),
    .bit_set (s_bit)
  );

  fdiv_finish #(.W(W)) u_finish (
    .quo_raw (quo_q),
    .res_neg (neg_q),
    .result  (f_result)
  );

  always_comb begin
    accept      = start && (state_q == FDV_IDLE);
    ovf_detect  = (state_q == FDV_PREP) && p_too_big;
    step_fire   = (state_q == FDV_RUN);
    last_step   = step_fire && (cnt_q == LAST_CNT);
    finish_fire = (state_q == FDV_FIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= FDV_IDLE;
      op_dvd_q  <= '0;
      op_dvr_q  <= '0;
      dvr_mag_q <= '0;
      neg_q     <= 1'b0;
      rem_q     <= '0;
      quo_q     <= '0;
      cnt_q     <= '0;
      result_q  <= '0;
      ovf_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        FDV_IDLE: begin
          if (accept) begin
            op_dvd_q <= dividend;
            op_dvr_q <= divisor;
            state_q  <= FDV_PREP;
          end
        end
        FDV_PREP: begin
          if (ovf_detect) begin
            ovf_q   <= 1'b1;
            done_q  <= 1'b1;
            state_q <= FDV_IDLE;
          end else begin
            rem_q     <= {1'b0, p_dvd_mag};
            dvr_mag_q <= p_dvr_mag;
            neg_q     <= p_neg;
            quo_q     <= '0;
            cnt_q     <= '0;
            state_q   <= FDV_RUN;
          end
        end
        FDV_RUN: begin
          rem_q <= s_rem;
          quo_q <= s_quo;
          cnt_q <= cnt_q + 1'b1;
          if (last_step) state_q <= FDV_FIN;
        end
        FDV_FIN: begin
          result_q <= f_result;
          ovf_q    <= 1'b0;
          done_q   <= 1'b1;
          state_q  <= FDV_IDLE;
        end
        default: state_q <= FDV_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != FDV_IDLE);
  assign done     = done_q;
  assign quotient = result_q;
  assign overflow = ovf_q;
endmodule

// File: rtl/frac_divider_chk.sv
module frac_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic         overflow,
  input logic         accept,
  input logic         ovf_detect,
  input logic         finish_fire
);
  localparam int LAT_W = $clog2(W + 4) + 1;
  logic [LAT_W-1:0] lat_q;

  // Cycles since the accepting edge, counted independently of the datapath.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (accept) lat_q <= LAT_W'(1);
    else if (busy)   lat_q <= lat_q + 1'b1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                             // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                             // R9
  AST_OVF_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_detect |=> (done && overflow));                          // R3
  AST_OVF_HOLDS_QUOT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && overflow) |-> $stable(quotient));                   // R3
  AST_OVF_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && overflow) |-> (lat_q == LAT_W'(2)));                // R3
  AST_EVEN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !overflow) |-> (quotient[0] == 1'b0));              // R6
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !overflow) |-> (lat_q == LAT_W'(W + 2)));           // R8
  AST_FINISH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    finish_fire |=> (done && !overflow));                        // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);                                            // R2
endmodule

bind frac_divider frac_divider_chk #(.W(W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .quotient    (quotient),
  .overflow    (overflow),
  .accept      (accept),
  .ovf_detect  (ovf_detect),
  .finish_fire (finish_fire)
);

// File: tb/test_frac_divider.sv
module test_frac_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done, overflow;
  logic [31:0] quotient;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [31:0] last_q = '0;

  always #10 clk = ~clk; // 50 MHz

  frac_divider i_frac_divider (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .overflow(overflow)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // Restatement of the requirements, written with integer arithmetic.
  function automatic logic [31:0] absval(input logic [31:0] v);
    return v[31] ? (32'd0 - v) : v;
  endfunction

  function automatic logic expect_ovf(input logic [31:0] a, input logic [31:0] b);
    return absval(a) >= absval(b);
  endfunction

  function automatic logic [31:0] expect_quo(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] num, q;
    logic [31:0] r;
    // 31 quotient bits of (|a| / |b|) scaled by 2^31, truncated (R5)
    num = {1'b0, absval(a), 31'd0};
    q = num / {32'd0, absval(b)};
    r = q[31:0] + 32'd1;                 // R6
    r[0] = 1'b0;
    if (a[31] ^ b[31]) r = 32'd0 - r;    // R4, R7
    return r;
  endfunction

  // Launch, optionally poke start mid-flight, wait for done, check.
  task automatic run(input logic [31:0] a, input logic [31:0] b, input bit poke);
    int n;
    logic eo;
    logic [31:0] eq;
    eo = expect_ovf(a, b);
    eq = eo ? last_q : expect_quo(a, b);
    @(negedge clk);
    dividend = a; divisor = b; start = 1'b1;
    n = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        start = 1'b0;
        check("R2 busy after accept", {31'd0, busy}, 32'd1);
      end
      if (poke && n == 5) begin
        dividend = ~a; divisor = 32'h0000_0003; start = 1'b1;
      end
      if (poke && n == 6) start = 1'b0;
      if (done || n > 60) break;
    end
    // done seen at negedge n: set on rising edge n-1 after the accepting edge
    check(eo ? "R3 latency" : "R8 latency", n, eo ? 32'd2 : 32'd34);
    check(eo ? "R3 overflow flag" : "R8 overflow clear", {31'd0, overflow}, {31'd0, eo});
    check(eo ? "R3 quotient held" : (poke ? "R2 start ignored while busy" : "R5 quotient"),
          quotient, eq);
    check("R9 busy low at done", {31'd0, busy}, 32'd0);
    @(negedge clk);
    check("R9 done single pulse", {31'd0, done}, 32'd0);
    last_q = eq;
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 overflow", {31'd0, overflow}, 32'd0);
    check("R1 quotient", quotient, 32'd0);
    rst_n = 1'b1;

    // Directed corners
    run(32'h2000_0000, 32'h4000_0000, 0);   // R5: 0.25/0.5
    run(32'hE000_0000, 32'h4000_0000, 0);   // R4 R7: negative result
    run(32'h0000_0000, 32'h0000_0000, 0);   // R3: zero divisor, zero dividend
    run(32'h1234_5678, 32'h0000_0000, 0);   // R3: zero divisor
    run(32'h4000_0000, 32'hC000_0000, 0);   // R3: equal magnitudes
    run(32'h8000_0000, 32'h8000_0000, 0);   // R3 R4: most negative both
    run(32'h7FFF_FFFF, 32'h8000_0000, 0);   // R6 R7: rounds to 2^31
    run(32'h0000_0000, 32'h8000_0000, 0);   // R6: zero quotient
    run(32'h0000_0001, 32'h7FFF_FFFF, 0);   // R5: tiny quotient
    run(32'hC000_0001, 32'h8000_0000, 0);   // R4: both negative
    run(32'h1000_0000, 32'h3000_0000, 1);   // R2: restart attempt ignored

    // Random mix: half chosen to produce proper fractions
    for (int i = 0; i < 200; i++) begin
      logic [31:0] a, b;
      b = $urandom;
      if (i % 2 == 0) begin
        a = absval(b) >> (1 + ($urandom % 8));
        if ($urandom % 2) a = 32'd0 - a;
      end else begin
        a = $urandom;
      end
      run(a, b, (i % 37) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule